// File: doc/BRIEF.md
# Four-Valued Sum-of-Products Array

This block evaluates a programmable sum-of-products function over several quaternary inputs, each carried as a 2-bit digit with values 0 to 3. The array has a set of product columns. Each column holds a window [lo, hi] for every input, an output constant from 0 to 3, and an off flag. A column is active when every input digit lies inside its own window. An active column contributes its constant. The block output is the sum of all contributions, clamped at 3. This clamped sum takes the place of the OR plane of a binary array, and each window takes the place of a true or complement literal.

Settings are loaded through a write port. Each write names a column, a field code and a 2-bit value, and takes effect at the next rising clock edge. The combinational evaluation is registered, so the output has one cycle of latency. A cover found offline is loaded column by column. Columns that are not needed stay off.

Top module: `qpla_top`

## Requirements
- R1: An input digit x is inside a column's window when lo ≤ x ≤ hi, with both bounds inclusive. After reset every window is lo = 0 and hi = 3.
- R2: A column contributes its constant only when every input digit is inside that column's window. If any digit is outside its window, the column contributes 0.
- R3: The output is the sum of all column contributions. A sum above 3 is clamped to 3.
- R4: A column whose off flag is set contributes 0, whatever its windows and inputs are.
- R5: A window with lo greater than hi contains no value, so its column is never active.
- R6: When cfg_we is high, the addressed field of the addressed column takes cfg_val at the rising edge. The output registered at that same edge still uses the old settings. When cfg_we is low, no setting changes.
- R7: Field codes on cfg_fld, with N inputs:
  - 2i writes the lower bound of input i.
  - 2i+1 writes the upper bound of input i.
  - 2N writes the column constant.
  - 2N+1 writes the off flag from cfg_val bit 0, where 1 means off.
  - Any other code changes nothing.
- R8: A synchronous active-high reset drives y_out to 0 at the next edge. It sets every column off, every constant to 0, and every window to [0, 3].
- R9: Input i occupies x_in[2i+1:2i]. y_out shows the function of the x_in value sampled at the previous rising edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 2*N_IN | Quaternary input digits; digit i in bits [2i+1:2i] |
| cfg_we | input | 1 | Setting write enable |
| cfg_col | input | COL_W | Column addressed by the write |
| cfg_fld | input | FLD_W | Field code (see R7) |
| cfg_val | input | 2 | Value written to the field |
| y_out | output | 2 | Registered clamped sum, 0 to 3 |

## Verification
The main test loads an eight-term cover of the quaternary modulo-4 sum and walks all 16 input pairs. The sums in this cover land exactly on 3 without exceeding it, and they reach the zero cells along the wrap diagonal. A wrong window comparison or a wrong clamp therefore changes specific cells. Further patterns set a constant high enough to push the sum past 3, switch off a single column, and invert one window. Each of these patterns changes only the cells that column covers. Writes issued with the enable low, writes with unused field codes, a write in the same cycle as an evaluation, and a reset in mid-run are each followed by evaluations that would reveal any stray change.

// File: rtl/qpla_pkg.sv
package qpla_pkg;

    localparam int QW = 2;
    localparam logic [QW-1:0] QTOP = 2'd3;

    typedef logic [QW-1:0] qdig_t;

    typedef struct packed {
        qdig_t lo;
        qdig_t hi;
    } qwin_t;

    typedef enum logic [2:0] {
        FK_LO,
        FK_HI,
        FK_CONST,
        FK_OFF,
        FK_NONE
    } fkind_t;

    function automatic qdig_t qsat_add(qdig_t a, qdig_t b);
        logic [QW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s > {1'b0, QTOP}) ? QTOP : s[QW-1:0];
    endfunction

endpackage

// File: rtl/qpla_cfg_bank.sv
module qpla_cfg_bank
    import qpla_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int N_COL = 8,
    localparam int COL_W = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int FLD_W = $clog2(2 * N_IN + 2),
    localparam int IN_W  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [COL_W-1:0]                  col,
    input  logic [FLD_W-1:0]                  fld,
    input  qdig_t                             val,
    output qwin_t [N_COL-1:0][N_IN-1:0]       win_q,
    output qdig_t [N_COL-1:0]                 cst_q,
    output logic  [N_COL-1:0]                 off_q
);

    fkind_t          kind;
    logic [IN_W-1:0] sel_in;

    always_comb begin
        kind   = FK_NONE;
        sel_in = '0;
        if (int'(fld) < 2 * N_IN) begin
            kind   = fld[0] ? FK_HI : FK_LO;
            sel_in = IN_W'(fld >> 1);
        end else if (int'(fld) == 2 * N_IN) begin
            kind = FK_CONST;
        end else if (int'(fld) == 2 * N_IN + 1) begin
            kind = FK_OFF;
        end
    end

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        logic  col_sel;
        qdig_t cst_r;
        logic  off_r;

        assign col_sel = we && (col == COL_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                cst_r <= '0;
                off_r <= 1'b1;
            end else if (col_sel) begin
                if (kind == FK_CONST) cst_r <= val;
                if (kind == FK_OFF)   off_r <= val[0];
            end
        end

        assign cst_q[c] = cst_r;
        assign off_q[c] = off_r;

        for (genvar i = 0; i < N_IN; i++) begin : g_in
            qwin_t w_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    w_r <= '{lo: '0, hi: QTOP};
                end else if (col_sel && sel_in == IN_W'(i)) begin
                    if (kind == FK_LO) w_r.lo <= val;
                    if (kind == FK_HI) w_r.hi <= val;
                end
            end

            assign win_q[c][i] = w_r;
        end
    end

endmodule

// File: rtl/qpla_term.sv
module qpla_term
    import qpla_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  qdig_t [N_IN-1:0] x,
    input  qwin_t [N_IN-1:0] win,
    input  qdig_t            cst,
    input  logic             off,
    output logic             hit,
    output qdig_t            val
);

    logic [N_IN-1:0] outside;

    for (genvar i = 0; i < N_IN; i++) begin : g_cell
        assign outside[i] = (x[i] < win[i].lo) || (x[i] > win[i].hi);
    end

    assign hit = !off && (outside == '0);
    assign val = hit ? cst : '0;

endmodule

// File: rtl/qpla_sat_sum.sv
module qpla_sat_sum
    import qpla_pkg::*;
#(
    parameter int N = 8
) (
    input  qdig_t [N-1:0] terms,
    output qdig_t         total
);

    always_comb begin
        total = '0;
        for (int k = 0; k < N; k++) begin
            total = qsat_add(total, terms[k]);
        end
    end

endmodule

// File: rtl/qpla_top.sv
module qpla_top
    import qpla_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int N_COL = 8,
    localparam int COL_W = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int FLD_W = $clog2(2 * N_IN + 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_IN*QW-1:0]   x_in,
    input  logic                 cfg_we,
    input  logic [COL_W-1:0]     cfg_col,
    input  logic [FLD_W-1:0]     cfg_fld,
    input  logic [QW-1:0]        cfg_val,
    output logic [QW-1:0]        y_out
);

    qdig_t [N_IN-1:0]             xv;
    qwin_t [N_COL-1:0][N_IN-1:0]  win_q;
    qdig_t [N_COL-1:0]            cst_q;
    logic  [N_COL-1:0]            off_q;
    logic  [N_COL-1:0]            col_hit;
    qdig_t [N_COL-1:0]            col_val;
    qdig_t                        sum_nxt;

    assign xv = x_in;

    qpla_cfg_bank #(.N_IN(N_IN), .N_COL(N_COL)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .col   (cfg_col),
        .fld   (cfg_fld),
        .val   (cfg_val),
        .win_q (win_q),
        .cst_q (cst_q),
        .off_q (off_q)
    );

    for (genvar c = 0; c < N_COL; c++) begin : g_term
        qpla_term #(.N_IN(N_IN)) u_term (
            .x   (xv),
            .win (win_q[c]),
            .cst (cst_q[c]),
            .off (off_q[c]),
            .hit (col_hit[c]),
            .val (col_val[c])
        );
    end

    qpla_sat_sum #(.N(N_COL)) u_sum (
        .terms (col_val),
        .total (sum_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) y_out <= '0;
        else     y_out <= sum_nxt;
    end

endmodule

// File: rtl/qpla_chk.sv
module qpla_chk
    import qpla_pkg::*;
#(
    parameter int N_COL = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input qdig_t             y_out,
    input logic [N_COL-1:0]  hit,
    input logic [N_COL-1:0]  off,
    input qdig_t [N_COL-1:0] cst
);

    logic full_hit;

    always_comb begin
        full_hit = 1'b0;
        for (int k = 0; k < N_COL; k++) begin
            if (hit[k] && cst[k] == QTOP) full_hit = 1'b1;
        end
    end

    // R8: reset clears the registered output
    a_r8_reset_zero: assert property (@(posedge clk)
        rst |=> y_out == '0);

    // R2: no active column gives a zero output next cycle
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> y_out == '0);

    // R3: one full-valued active column drives the clamped top value
    a_r3_clamp_top: assert property (@(posedge clk) disable iff (rst)
        full_hit |=> y_out == QTOP);

    // R4: a column that is off never reports a hit
    a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
        (hit & off) == '0);

    // R6: settings hold while the write enable is low
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(off) && $stable(cst)));

endmodule

bind qpla_top qpla_chk #(.N_COL(N_COL)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_we (cfg_we),
    .y_out  (y_out),
    .hit    (col_hit),
    .off    (off_q),
    .cst    (cst_q)
);

// File: tb/qpla_top_tb.sv
`timescale 1ns/1ps
module qpla_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] x_in = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_col = '0;
    logic [2:0] cfg_fld = '0;
    logic [1:0] cfg_val = '0;
    logic [1:0] y_out;

    always #2.5 clk = ~clk;

    qpla_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .x_in    (x_in),
        .cfg_we  (cfg_we),
        .cfg_col (cfg_col),
        .cfg_fld (cfg_fld),
        .cfg_val (cfg_val),
        .y_out   (y_out)
    );

    int    n_run = 0;
    int    n_fail = 0;
    int    m_lo [8][2];
    int    m_hi [8][2];
    int    m_c  [8];
    int    m_off[8];
    int    exp_y = 0;
    bit    have_exp = 0;
    string exp_tag = "";

    // behavioural reference: windows, constants, off flags, clamp at 3
    function automatic int model(int a, int b);
        int s = 0;
        for (int c = 0; c < 8; c++) begin
            if (m_off[c] == 0 &&
                a >= m_lo[c][0] && a <= m_hi[c][0] &&
                b >= m_lo[c][1] && b <= m_hi[c][1])
                s += m_c[c];
        end
        return (s > 3) ? 3 : s;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 8; c++) begin
            m_lo[c][0] = 0; m_hi[c][0] = 3;
            m_lo[c][1] = 0; m_hi[c][1] = 3;
            m_c[c] = 0;     m_off[c] = 1;
        end
    endtask

    task automatic model_write(int col, int fld, int val);
        if (fld < 4) begin
            if (fld % 2 == 0) m_lo[col][fld / 2] = val;
            else              m_hi[col][fld / 2] = val;
        end else if (fld == 4) begin
            m_c[col] = val;
        end else if (fld == 5) begin
            m_off[col] = val & 1;
        end
    endtask

    // one cycle: check the result of the previous stimulus, then drive the next
    task automatic cyc(input bit r, input int a, input int b, input bit we,
                       input int col, input int fld, input int val, input string tag);
        @(negedge clk);
        if (have_exp) begin
            n_run++;
            if (y_out !== 2'(exp_y)) begin
                n_fail++;
                $display("FAIL %s: y_out=%0d expected %0d", exp_tag, y_out, exp_y);
            end
        end
        rst     = r;
        x_in    = {2'(b), 2'(a)};
        cfg_we  = we;
        cfg_col = 3'(col);
        cfg_fld = 3'(fld);
        cfg_val = 2'(val);
        if (r) begin
            exp_y = 0;
            model_reset();
        end else begin
            exp_y = model(a, b);
            if (we) model_write(col, fld, val);
        end
        have_exp = 1;
        exp_tag  = tag;
    endtask

    // evaluation with a would-be write held off (R6: enable low)
    task automatic ev(input int a, input int b, input string tag);
        cyc(0, a, b, 0, 7, 4, 3, tag);
    endtask

    task automatic wr(input int col, input int fld, input int val, input string tag);
        cyc(0, 0, 0, 1, col, fld, val, tag);
    endtask

    // R7 field codes: 0/1 bounds of input0, 2/3 bounds of input1, 4 constant, 5 off
    task automatic load(input int col, input int a0, input int b0,
                        input int a1, input int b1, input int c);
        wr(col, 0, a0, "R7 load");
        wr(col, 1, b0, "R7 load");
        wr(col, 2, a1, "R7 load");
        wr(col, 3, b1, "R7 load");
        wr(col, 4, c,  "R7 load");
        wr(col, 5, 0,  "R7 load");
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                ev(a, b, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        // R8: reset state
        cyc(1, 0, 0, 0, 0, 0, 0, "R8 reset");
        cyc(1, 3, 3, 0, 0, 0, 0, "R8 reset");
        sweep("R8 all columns off after reset");

        // R1 R2 R3 R9: eight-term cover of (x + y) mod 4
        load(0, 2, 2, 0, 1, 2);
        load(1, 0, 2, 1, 1, 1);
        load(2, 1, 1, 0, 2, 1);
        load(3, 0, 1, 2, 2, 2);
        load(4, 3, 3, 0, 0, 3);
        load(5, 0, 0, 3, 3, 3);
        load(6, 2, 3, 3, 3, 1);
        load(7, 3, 3, 2, 3, 1);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                ev(a, b, "R2 modsum cover");
                exp_y = (a + b) % 4;
            end
        sweep("R1 R9 window edges and latency");

        // R7: unused field codes change nothing
        wr(4, 6, 0, "R7 unused code");
        wr(6, 7, 3, "R7 unused code");
        sweep("R7 unused code no effect");

        // R4 and R6: off write in same cycle as evaluation uses old settings
        cyc(0, 3, 0, 1, 4, 5, 1, "R6 write same cycle uses old");
        ev(3, 0, "R4 column off");
        ev(3, 0, "R4 column off");
        cyc(0, 3, 0, 1, 4, 5, 0, "R6 write same cycle uses old");
        ev(3, 0, "R4 column back on");

        // R5: inverted window on column 7
        wr(7, 2, 3, "R5 load");
        wr(7, 3, 2, "R5 load");
        ev(3, 2, "R5 inverted window");
        ev(3, 3, "R5 inverted window");
        sweep("R5 inverted window");

        // R3: overflow clamps at 3
        wr(3, 4, 3, "R3 load");
        ev(1, 2, "R3 clamp");
        ev(0, 2, "R3 clamp");
        sweep("R3 clamp");

        // R8: reset in mid-run wipes settings
        cyc(1, 2, 1, 0, 0, 0, 0, "R8 mid reset");
        sweep("R8 settings cleared");
        ev(0, 0, "R8 flush");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule